// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This peripheral sits on an APB3-style bus and produces an interrupt once every X clock cycles, where X is a 32-bit period that software writes. Four word registers in one 256-byte window are selected by the low address bits. A control word starts and stops counting and clears the count. A period word holds X. A read-only count word shows the current tick. A status word records that an expiry happened and clears itself when it is read.

The count runs from zero up to X-1 while the timer runs. The step after X-1 returns the count to zero and raises `irq` for exactly one cycle, so a level-sensitive interrupt input sees one request per expiry. A period of zero behaves like a period of one. A period written while the timer runs is used from the next cycle. Stopping the timer freezes the count, and starting it again resumes from the frozen value.

Top module: `periodic_timer`

## Requirements
- R1: After synchronous reset, `irq` is low and the control, period, count and status words all read as zero.
- R2: The period word at offset 0x04 stores all 32 bits written to it and reads them back unchanged.
- R3: While running with period X of one or more, the count steps 0 to X-1. The step from X-1 loads zero and drives `irq` high for one cycle, X cycles after the previous expiry.
- R4: A stored period of zero reads back as zero but counts as one: `irq` is high on every cycle while running.
- R5: Bit 0 of the control word at offset 0x00 is the run flag. While it is 0 the count holds and `irq` stays low. Setting it again resumes counting from the held value.
- R6: Writing 1 to bit 1 of the control word zeroes the count at that write. That bit always reads as 0. If the clear falls on the same cycle as an expiry, the clear wins and no interrupt is raised.
- R7: The count word at offset 0x08 returns the current count, and writes to it have no effect.
- R8: Bit 0 of the status word at offset 0x0C is set on every expiry and cleared by a read of that word. An expiry on the same cycle as the clearing read leaves the bit set.
- R9: A new period written while running is used from the next cycle. If the count is already at or above the new X-1, the timer expires on that next cycle.
- R10: Offsets other than the four words read as zero, writes to them or to the status word change nothing, and `pready` is always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset within the window |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during the access phase |
| pready | output | 1 | Always high, no wait states |
| irq | output | 1 | One-cycle pulse per expiry |

## Verification
Two pairs of events can fall on the same cycle. A status read can land on the cycle an expiry sets the status bit. The bench provokes this by reading status with a period of zero, so that every cycle expires, and expects the bit to read 1 on both of two back-to-back reads. A count clear can land on the cycle the count reaches X-1. The bench provokes this by issuing two clearing control writes three cycles apart with a period of three. It expects no `irq` pulse on the cycle after the second write and the first pulse three cycles later.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } decode_t;

    typedef struct packed {
        logic run;
        logic clr;
    } ctrl_t;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;

    // Word offsets 0x00..0x0C map to the four registers; anything else misses.
    function automatic decode_t decode_off(input logic [7:0] off);
        decode_t d;
        d.hit = (off[7:4] == 4'h0) && (off[1:0] == 2'b00);
        d.sel = reg_sel_e'(off[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/timer_regif.sv
module timer_regif
    import timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              expire,
    output logic [DATA_W-1:0] prdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] period,
    output logic              status
);

    decode_t dec;
    logic    acc_wr, acc_rd;
    logic    run_q;

    always_comb begin
        dec    = decode_off(paddr[7:0]);
        acc_wr = psel && penable && pwrite && dec.hit;
        acc_rd = psel && penable && !pwrite && dec.hit;
    end

    // Clear request acts on the same edge as the write that carries it.
    assign ctrl.run = run_q;
    assign ctrl.clr = acc_wr && (dec.sel == SEL_CTRL) && pwdata[CTRL_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            period <= '0;
            status <= 1'b0;
        end else begin
            if (acc_wr && dec.sel == SEL_CTRL)
                run_q <= pwdata[CTRL_RUN_BIT];
            if (acc_wr && dec.sel == SEL_PERIOD)
                period <= pwdata;
            // A fresh expiry outranks the clearing read.
            status <= expire || (status && !(acc_rd && dec.sel == SEL_STATUS));
        end
    end

    always_comb begin
        prdata = '0;
        if (acc_rd) begin
            unique case (dec.sel)
                SEL_CTRL:   prdata[CTRL_RUN_BIT] = run_q;
                SEL_PERIOD: prdata = period;
                SEL_COUNT:  prdata = cnt;
                SEL_STATUS: prdata[0] = status;
            endcase
        end
    end

endmodule

// File: rtl/timer_counter.sv
module timer_counter
    import timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             irq
);

    logic [CNT_W-1:0] last;

    // Period zero collapses to a last tick of zero, i.e. period one.
    always_comb begin
        last   = (period == '0) ? '0 : period - 1'b1;
        expire = ctrl.run && !ctrl.clr && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= expire;
            if (ctrl.clr)
                cnt <= '0;
            else if (expire)
                cnt <= '0;
            else if (ctrl.run)
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
    import timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] period;
    logic [DATA_W-1:0] cnt;
    logic              expire;
    logic              status;

    assign pready = 1'b1;

    timer_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .cnt(cnt), .expire(expire),
        .prdata(prdata), .ctrl(ctrl), .period(period), .status(status)
    );

    timer_counter #(.CNT_W(DATA_W)) u_counter (
        .clk(clk), .rst(rst), .ctrl(ctrl), .period(period),
        .cnt(cnt), .expire(expire), .irq(irq)
    );

endmodule

// File: rtl/periodic_timer_chk.sv
module periodic_timer_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              irq,
    input logic              run,
    input logic              clr,
    input logic              expire,
    input logic              status,
    input logic [DATA_W-1:0] cnt
);

    logic rd_status;
    assign rd_status = psel && penable && !pwrite && (paddr[7:0] == 8'h0C);

    p_irq_wraps_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == '0));

    p_irq_flags_status_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> status);

    p_stop_holds_count_r5: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cnt));

    p_stop_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> !irq);

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((cnt == '0) && !irq));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !expire) |=> !status);

endmodule

bind periodic_timer periodic_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .irq(irq), .run(ctrl.run), .clr(ctrl.clr),
    .expire(expire), .status(status), .cnt(cnt)
);

// File: tb/periodic_timer_tb.sv
module periodic_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, irq;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [31:0] exp;
        bit          chk;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    periodic_timer dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    endtask

    // Monitor: compares read data in the access phase against the scoreboard.
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", prdata, 32'h0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                if (it.chk) check(prdata == it.exp, it.tag, prdata, it.exp);
                check(pready == 1'b1, "R10 pready high", {31'h0, pready}, 32'h1);
            end
        end
    end

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, input logic [31:0] e, input bit chk, input string tag);
        exp_t it;
        it.exp = e; it.chk = chk; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    // Watches irq for n cycles: pulse count, index of first pulse, spacing.
    task automatic watch_irq(input int n, input int exp_cnt, input int exp_first,
                             input int exp_gap, input string tag);
        int pulses = 0, first = 0, prev = 0;
        bit gap_ok = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (irq) begin
                pulses++;
                if (first == 0) first = k;
                if (prev != 0 && (k - prev) != exp_gap) gap_ok = 1'b0;
                prev = k;
            end
        end
        check(pulses == exp_cnt, {tag, " pulse count"}, pulses, exp_cnt);
        if (exp_cnt > 0) begin
            check(first == exp_first, {tag, " first pulse"}, first, exp_first);
            check(gap_ok, {tag, " pulse spacing"}, {31'h0, gap_ok}, 32'h1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R1 irq low after reset", {31'h0, irq}, 32'h0);
        apb_read(8'h00, 32'h0, 1, "R1 ctrl reset");
        apb_read(8'h04, 32'h0, 1, "R1 period reset");
        apb_read(8'h08, 32'h0, 1, "R1 count reset");
        apb_read(8'h0C, 32'h0, 1, "R1 status reset");

        // R2 / R10
        apb_write(8'h04, 32'hA5A5_1234);
        apb_read(8'h04, 32'hA5A5_1234, 1, "R2 period readback");
        apb_write(8'h10, 32'hDEAD_BEEF);
        apb_read(8'h10, 32'h0, 1, "R10 unmapped reads zero");
        apb_read(8'h04, 32'hA5A5_1234, 1, "R10 unmapped write ignored");

        // R3: period 5
        apb_write(8'h04, 32'd5);
        apb_write(8'h00, 32'h3);
        watch_irq(20, 3, 6, 5, "R3 period 5");
        apb_write(8'h00, 32'h0);

        // R4: period 0 acts as 1; R8 collision of read and expiry
        apb_write(8'h04, 32'd0);
        apb_read(8'h04, 32'h0, 1, "R4 period zero stored");
        apb_write(8'h00, 32'h3);
        watch_irq(20, 19, 2, 1, "R4 period zero");
        apb_read(8'h0C, 32'h1, 1, "R8 status set");
        apb_read(8'h0C, 32'h1, 1, "R8 expiry beats clearing read");
        apb_write(8'h00, 32'h0);
        apb_read(8'h0C, 32'h1, 1, "R8 status after stop");
        apb_read(8'h0C, 32'h0, 1, "R8 read clears status");

        // R5: stop holds, restart resumes
        apb_write(8'h04, 32'd100);
        apb_write(8'h00, 32'h3);
        apb_write(8'h00, 32'h0);
        apb_read(8'h08, 32'd3, 1, "R5 count held at stop");
        watch_irq(10, 0, 0, 0, "R5 no irq while stopped");
        apb_read(8'h08, 32'd3, 1, "R5 count still held");
        apb_write(8'h00, 32'h1);
        apb_read(8'h08, 32'd5, 1, "R5 resume from held count");

        // R6: clear count, bit reads zero, clear beats expiry
        apb_write(8'h00, 32'h3);
        apb_read(8'h08, 32'd2, 1, "R6 count cleared");
        apb_read(8'h00, 32'h1, 1, "R6 clear bit reads zero");
        apb_write(8'h00, 32'h0);
        apb_read(8'h0C, 32'h0, 0, "flush status");
        apb_write(8'h04, 32'd3);
        apb_write(8'h00, 32'h3);
        apb_write(8'h00, 32'h3);
        watch_irq(4, 1, 4, 0, "R6 clear suppresses expiry");
        apb_write(8'h00, 32'h0);
        apb_read(8'h0C, 32'h1, 1, "R8 status after expiry");
        apb_read(8'h0C, 32'h0, 1, "R8 cleared by read");

        // R9: shrink period below current count
        apb_write(8'h04, 32'd100);
        apb_write(8'h00, 32'h3);
        apb_read(8'h08, 32'd2, 1, "R9 count before shrink");
        apb_write(8'h04, 32'd4);
        watch_irq(12, 3, 2, 4, "R9 immediate expiry");

        // R7 / R10: read-only count, status write ignored
        apb_write(8'h00, 32'h2);
        apb_read(8'h00, 32'h0, 1, "R6 stopped with clear");
        apb_write(8'h08, 32'h0000_FFFF);
        apb_read(8'h08, 32'h0, 1, "R7 count write ignored");
        apb_read(8'h0C, 32'h0, 0, "flush status");
        apb_write(8'h0C, 32'hFFFF_FFFF);
        apb_read(8'h0C, 32'h0, 1, "R10 status write ignored");

        @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 32'h0);
        finish_run();
    end

endmodule